// File: doc/BRIEF.md
# Boundary-Scan Test Access Port for a 32-Lane Demultiplexer Output Side

This block is the test access port that sits on the low-speed side of a serial-to-32-lane demultiplexer. It is driven by a four-wire serial test interface: a test clock, a mode-select line, a serial data input and an active-low asynchronous reset. It returns one serial data output and a separate enable for that output. Inside it are the usual sixteen-state access-port controller, a two-bit instruction register, a one-bit bypass stage and a single 34-stage shift chain. The lower 32 stages of that chain also carry the device identification word.

The boundary cells sit on the 32 parallel data outputs, the word-clock output and the mode-select input pin. In normal operation the core's data and word clock pass straight to the pins. When external test is selected, the pins take the values last written into the cells' update stage. A preload instruction fills that update stage without disturbing the pins, so that a known pattern is in place before external test begins.

Top module: `bscan_tap`

## Requirements
- R1: The instruction register is 2 bits wide and takes effect on Update-IR: 00 selects external test, 01 selects preload, 10 selects identification, 11 selects bypass.
- R2: Pulling trst_n low puts the controller into Test-Logic-Reset and the instruction into identification at once, without waiting for a clock edge. From that moment the pins carry the core values.
- R3: Under identification the scan path is 32 bits long. It captures the value 0x149E803B, which shifts out least significant bit first.
- R4: Under bypass the scan path is a single stage that captures 0 in Capture-DR.
- R5: The boundary chain positions are fixed. Position 0 is the mode-select input. Positions 1 to 8 are data lanes 0,4,...,28. Position 9 is the word clock. Positions 10 to 17 are lanes 1,5,...,29. Positions 18 to 25 are lanes 2,6,...,30. Positions 26 to 33 are lanes 3,7,...,31. Position 0 leaves TDO first.
- R6: Under external test, every data pin and the word-clock pin take the value held in its cell's update stage.
- R7: Under preload, Update-DR loads the update stage while the pins keep carrying the core values.
- R8: In Capture-DR under external test or preload, each output cell captures the value currently on its pin, and position 0 captures the mode-select input.
- R9: tdo_en is high only while the controller is in Shift-DR or Shift-IR. TDO changes only on falling TCK edges.
- R10: Five consecutive TCK rising edges with TMS high bring the controller to Test-Logic-Reset from any state, which restores the identification instruction.
- R11: Capture-IR loads binary 01 into the instruction shift stage, so 01 is the first pair of bits seen on TDO during Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | High while TDO carries shifted data |
| core_dout | input | 32 | Data lanes from the core |
| core_wclk | input | 1 | Word clock from the core |
| pin_mode | input | 1 | Mode-select pin, observed by cell 0 |
| pin_dout | output | 32 | Data lanes toward the pins |
| pin_wclk | output | 1 | Word clock toward the pins |

## Verification
Four lane patterns go through a preload, external-test, recapture sequence: an alternating pattern, all ones against all zeros, a walking single bit, and a mixed word. Each pattern uses a different mode-pin and word-clock value. A chain that is mis-ordered or misses a lane shows up as a bit in the wrong place in one of the captures or on the pins. Preload is kept apart from external test by checking that the pins stay on the core values after preload. The identification word is shifted 34 bits long, which exposes a wrong path length. A bypass shift checks the one-cycle delay and the captured 0. Separate runs cover asynchronous reset, reset through TMS, and TDO holding steady across rising edges.

// File: rtl/bscan_pkg.sv
// Shared types and constants for the boundary-scan access port.
// Assumes a data width that is a multiple of the lane count.
package bscan_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        OP_EXTEST  = 2'b00,
        OP_PRELOAD = 2'b01,
        OP_IDCODE  = 2'b10,
        OP_BYPASS  = 2'b11
    } tap_op_e;

    localparam int          ID_BITS  = 32;
    localparam logic [31:0] ID_WORD  = 32'h149E803B;
    localparam logic [1:0]  IR_CAPT  = 2'b01;

    // Chain position of data lane j: lane 0 group sits below the word clock,
    // later groups follow it.
    function automatic int lane_pos(input int j, input int lanes, input int per);
        int grp;
        int sub;
        grp = j / lanes;
        sub = j % lanes;
        return (sub == 0) ? (1 + grp) : (2 + sub * per + grp);
    endfunction

endpackage

// File: rtl/bscan_fsm.sv
// Sixteen-state access-port controller.
// Assumes TMS is stable around rising TCK; trst_n acts asynchronously.
module bscan_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q
);

    tap_state_e state_d;

    // Next-state decode of the standard controller graph.
    always_comb begin
        unique case (state_q)
            ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_d = ST_RESET;
        endcase
    end

    // State register, forced to Test-Logic-Reset by trst_n.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

endmodule

// File: rtl/bscan_ir.sv
// Two-bit instruction register with its shift stage.
// Assumes the controller state is registered on the same TCK edge.
module bscan_ir
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state_q,
    output tap_op_e    op_q,
    output logic       ir_lsb
);

    logic [1:0] ir_sr;

    // Shift stage: capture the fixed pattern, then shift toward the LSB.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                  ir_sr <= IR_CAPT;
        else if (state_q == ST_CAP_IR) ir_sr <= IR_CAPT;
        else if (state_q == ST_SH_IR)  ir_sr <= {tdi, ir_sr[1]};
    end

    // Active instruction: identification after reset, loaded on Update-IR.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                   op_q <= OP_IDCODE;
        else if (state_q == ST_RESET)  op_q <= OP_IDCODE;
        else if (state_q == ST_UPD_IR) op_q <= tap_op_e'(ir_sr);
    end

    assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/bscan_dr.sv
// Data registers: shared boundary/identification chain, its update stage
// and the bypass stage. Assumes CHAIN_W is larger than ID_BITS.
module bscan_dr
    import bscan_pkg::*;
#(
    parameter int CHAIN_W = 34
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  tap_state_e         state_q,
    input  tap_op_e            op_q,
    input  logic [CHAIN_W-1:0] cap_vec,
    output logic [CHAIN_W-1:1] upd_q,
    output logic               chain_lsb,
    output logic               byp_q
);

    logic [CHAIN_W-1:0] chain_q;
    logic               is_bnd;

    assign is_bnd = (op_q == OP_EXTEST) || (op_q == OP_PRELOAD);

    // Shared chain: boundary capture or identification word, then shifting.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            chain_q <= '0;
        end else if (state_q == ST_CAP_DR) begin
            if (is_bnd)                 chain_q <= cap_vec;
            else if (op_q == OP_IDCODE) chain_q[ID_BITS-1:0] <= ID_WORD;
        end else if (state_q == ST_SH_DR) begin
            if (is_bnd)                 chain_q <= {tdi, chain_q[CHAIN_W-1:1]};
            else if (op_q == OP_IDCODE) chain_q[ID_BITS-1:0] <= {tdi, chain_q[ID_BITS-1:1]};
        end
    end

    // Update stage for the output cells, written on Update-DR.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                              upd_q <= '0;
        else if (state_q == ST_UPD_DR && is_bnd)  upd_q <= chain_q[CHAIN_W-1:1];
    end

    // Bypass stage: zero on capture, one-bit delay while shifting.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                   byp_q <= 1'b0;
        else if (state_q == ST_CAP_DR) byp_q <= 1'b0;
        else if (state_q == ST_SH_DR)  byp_q <= tdi;
    end

    assign chain_lsb = chain_q[0];

endmodule

// File: rtl/bscan_tap.sv
// Top of the boundary-scan access port: controller, instruction and data
// registers, pin multiplexing and the falling-edge TDO stage.
// Assumes NDATA is a multiple of LANES.
module bscan_tap
    import bscan_pkg::*;
#(
    parameter int NDATA = 32,
    parameter int LANES = 4
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    input  logic [NDATA-1:0] core_dout,
    input  logic             core_wclk,
    input  logic             pin_mode,
    output logic [NDATA-1:0] pin_dout,
    output logic             pin_wclk
);

    localparam int PER     = NDATA / LANES;
    localparam int CHAIN_W = NDATA + 2;
    localparam int WCLK_AT = PER + 1;

    tap_state_e         state_q;
    tap_op_e            op_q;
    logic               ir_lsb;
    logic               chain_lsb;
    logic               byp_q;
    logic [CHAIN_W-1:1] upd_q;
    logic [CHAIN_W-1:0] cap_vec;
    logic               drive_ext;
    logic               tdo_src;

    bscan_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state_q(state_q)
    );

    bscan_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state_q(state_q),
        .op_q(op_q), .ir_lsb(ir_lsb)
    );

    bscan_dr #(.CHAIN_W(CHAIN_W)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .state_q(state_q), .op_q(op_q),
        .cap_vec(cap_vec), .upd_q(upd_q), .chain_lsb(chain_lsb), .byp_q(byp_q)
    );

    assign drive_ext = (op_q == OP_EXTEST);

    // Per-lane pin multiplexer and capture wiring at the fixed chain position.
    for (genvar j = 0; j < NDATA; j++) begin : g_lane
        localparam int POS = lane_pos(j, LANES, PER);
        assign pin_dout[j] = drive_ext ? upd_q[POS] : core_dout[j];
        assign cap_vec[POS] = pin_dout[j];
    end

    assign pin_wclk         = drive_ext ? upd_q[WCLK_AT] : core_wclk;
    assign cap_vec[WCLK_AT] = pin_wclk;
    assign cap_vec[0]       = pin_mode;

    // Serial output source for the current shift state.
    always_comb begin
        if (state_q == ST_SH_IR)      tdo_src = ir_lsb;
        else if (op_q == OP_BYPASS)   tdo_src = byp_q;
        else                          tdo_src = chain_lsb;
    end

    // Falling-edge output stage for TDO and its enable.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= tdo_src;
            tdo_en <= (state_q == ST_SH_DR) || (state_q == ST_SH_IR);
        end
    end

endmodule

// File: rtl/bscan_tap_chk.sv
// Protocol checks for bscan_tap, attached by bind.
module bscan_tap_chk
    import bscan_pkg::*;
#(
    parameter int NDATA = 32
) (
    input logic             tck,
    input logic             trst_n,
    input logic             tms,
    input logic             tdo_en,
    input tap_state_e       state_q,
    input tap_op_e          op_q,
    input logic             ir_lsb,
    input logic             chain_lsb,
    input logic             byp_q,
    input logic             pin_mode,
    input logic [NDATA-1:0] pin_dout,
    input logic [NDATA-1:0] core_dout
);

    // R9
    tdo_en_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state_q == ST_SH_DR || state_q == ST_SH_IR));

    // R2
    reset_op_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_RESET) |=> (op_q == OP_IDCODE));

    // R10
    tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state_q == ST_RESET));

    // R11
    ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_IR) |=> ir_lsb);

    // R4
    bypass_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_DR && op_q == OP_BYPASS) |=> !byp_q);

    // R8
    mode_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_CAP_DR && (op_q == OP_EXTEST || op_q == OP_PRELOAD))
        |=> (chain_lsb == $past(pin_mode)));

    // R7
    core_pass_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (op_q != OP_EXTEST) |-> (pin_dout == core_dout));

endmodule

bind bscan_tap bscan_tap_chk #(.NDATA(NDATA)) u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_en(tdo_en),
    .state_q(state_q), .op_q(op_q), .ir_lsb(ir_lsb), .chain_lsb(chain_lsb),
    .byp_q(byp_q), .pin_mode(pin_mode), .pin_dout(pin_dout), .core_dout(core_dout)
);

// File: tb/bscan_tap_tb.sv
module bscan_tap_tb;

    localparam int TCK_PERIOD = 20;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo, tdo_en;
    logic [31:0] core_dout = '0;
    logic        core_wclk = 1'b0;
    logic        pin_mode = 1'b0;
    logic [31:0] pin_dout;
    logic        pin_wclk;

    int checks = 0;
    int fails  = 0;
    int en_err = 0;
    int hold_err = 0;
    bit done = 1'b0;

    localparam logic [31:0] VEC_CORE [4] = '{32'hAAAA5555, 32'hFFFFFFFF, 32'h00010000, 32'h3C96E10F};
    localparam logic        VEC_WCLK [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic        VEC_MODE [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [33:0] VEC_PAT  [4] = '{34'h0_5555AAAA, 34'h0_00000000, 34'h0_00000200, 34'h2_9D0C3B64};

    always #(TCK_PERIOD/2) tck = ~tck;

    bscan_tap u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .core_dout(core_dout), .core_wclk(core_wclk), .pin_mode(pin_mode),
        .pin_dout(pin_dout), .pin_wclk(pin_wclk)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Chain position of lane j per R5: groups of 8 with bases 1, 10, 18, 26.
    function automatic int pos_of(input int j);
        int base;
        case (j % 4)
            0: base = 1;
            1: base = 10;
            2: base = 18;
            default: base = 26;
        endcase
        return base + j / 4;
    endfunction

    function automatic logic [33:0] to_chain(input logic [31:0] d, input logic w, input logic m);
        logic [33:0] v;
        v = '0;
        v[0] = m;
        v[9] = w;
        for (int j = 0; j < 32; j++) v[pos_of(j)] = d[j];
        return v;
    endfunction

    function automatic logic [31:0] from_chain(input logic [33:0] v);
        logic [31:0] d;
        for (int j = 0; j < 32; j++) d[j] = v[pos_of(j)];
        return d;
    endfunction

    // One TCK cycle: sample TDO after the falling edge, drive, check it holds past the rising edge.
    task automatic tbit(input logic tms_v, input logic tdi_v, input bit want_en, output logic tdo_v);
        @(negedge tck); #2;
        tdo_v = tdo;
        if (tdo_en !== want_en) en_err++;
        tms = tms_v; tdi = tdi_v;
        @(posedge tck); #2;
        if (tdo !== tdo_v) hold_err++;
    endtask

    task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
        logic t;
        dout = '0;
        tbit(1, 0, 0, t);
        tbit(0, 0, 0, t);
        tbit(0, 0, 0, t);
        for (int i = 0; i < n; i++) begin
            tbit(i == n - 1, din[i], 1, t);
            dout[i] = t;
        end
        tbit(1, 0, 0, t);
        tbit(0, 0, 0, t);
    endtask

    task automatic scan_ir(input logic [1:0] op, output logic [1:0] cap);
        logic t;
        tbit(1, 0, 0, t);
        tbit(1, 0, 0, t);
        tbit(0, 0, 0, t);
        tbit(0, 0, 0, t);
        tbit(0, op[0], 1, t); cap[0] = t;
        tbit(1, op[1], 1, t); cap[1] = t;
        tbit(1, 0, 0, t);
        tbit(0, 0, 0, t);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(TCK_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [63:0] o;
        logic [1:0]  c;
        logic        t;

        // Reset state
        core_dout = 32'h12345678; core_wclk = 1'b1;
        #(TCK_PERIOD * 3 + 3);
        chk(tdo_en === 1'b0, "R9 enable low in reset", tdo_en, 0);
        chk(pin_dout === core_dout, "R2 pins follow core after reset", pin_dout, core_dout);
        trst_n = 1'b1;
        tbit(0, 0, 0, t);

        // Identification by default, 32-bit path (R3)
        scan_dr(64'h3, 34, o);
        chk(o[31:0] === 32'h149E803B, "R3 id word", o[31:0], 32'h149E803B);
        chk(o[33:32] === 2'b11, "R3 id path length", o[33:32], 2'b11);

        // Capture-IR pattern (R11), then bypass (R4, R1)
        scan_ir(2'b11, c);
        chk(c === 2'b01, "R11 capture-ir 01", c, 2'b01);
        scan_dr(64'hB7, 8, o);
        chk(o[7:0] === {7'h37, 1'b0}, "R4 bypass delay and zero capture", o[7:0], {7'h37, 1'b0});

        // Table walk: preload, external test, recapture (R1 R5 R6 R7 R8)
        for (int k = 0; k < 4; k++) begin
            core_dout = VEC_CORE[k]; core_wclk = VEC_WCLK[k]; pin_mode = VEC_MODE[k];
            scan_ir(2'b01, c);
            scan_dr({30'b0, VEC_PAT[k]}, 34, o);
            chk(o[33:0] === to_chain(VEC_CORE[k], VEC_WCLK[k], VEC_MODE[k]),
                "R8 preload capture of core pins", o[33:0], to_chain(VEC_CORE[k], VEC_WCLK[k], VEC_MODE[k]));
            chk(pin_dout === VEC_CORE[k] && pin_wclk === VEC_WCLK[k],
                "R7 preload leaves pins on core", {pin_wclk, pin_dout}, {VEC_WCLK[k], VEC_CORE[k]});
            scan_ir(2'b00, c);
            chk(pin_dout === from_chain(VEC_PAT[k]), "R6 R5 extest drives lanes",
                pin_dout, from_chain(VEC_PAT[k]));
            chk(pin_wclk === VEC_PAT[k][9], "R6 R5 extest drives word clock", pin_wclk, VEC_PAT[k][9]);
            scan_dr({30'b0, ~VEC_PAT[k]}, 34, o);
            chk(o[33:0] === to_chain(from_chain(VEC_PAT[k]), VEC_PAT[k][9], VEC_MODE[k]),
                "R8 extest capture of driven pins", o[33:0],
                to_chain(from_chain(VEC_PAT[k]), VEC_PAT[k][9], VEC_MODE[k]));
            chk(pin_dout === from_chain(~VEC_PAT[k]), "R6 extest second update",
                pin_dout, from_chain(~VEC_PAT[k]));
        end

        // Five TMS highs return to reset and identification (R10)
        for (int i = 0; i < 5; i++) tbit(1, 0, 0, t);
        chk(pin_dout === core_dout, "R10 tms reset releases pins", pin_dout, core_dout);
        tbit(0, 0, 0, t);
        scan_dr(64'h0, 32, o);
        chk(o[31:0] === 32'h149E803B, "R10 id restored", o[31:0], 32'h149E803B);

        // Asynchronous reset mid-cycle (R2)
        scan_ir(2'b00, c);
        chk(pin_dout === from_chain(~VEC_PAT[3]), "R1 extest reselected", pin_dout, from_chain(~VEC_PAT[3]));
        @(posedge tck); #(TCK_PERIOD/4);
        trst_n = 1'b0;
        #1;
        chk(pin_dout === core_dout, "R2 async reset releases pins", pin_dout, core_dout);
        #(TCK_PERIOD);
        trst_n = 1'b1; tms = 1'b1;
        tbit(0, 0, 0, t);

        // Enable and falling-edge timing over the whole run (R9)
        chk(en_err == 0, "R9 tdo_en only in shift states", en_err, 0);
        chk(hold_err == 0, "R9 tdo stable across rising edge", hold_err, 0);

        done = 1'b1;
        summary();
    end

endmodule